// File: doc/BRIEF.md
# I/O Bridge Downstream Address Window Decoder

This block sits on the upstream side of an I/O bridge. It looks at each transaction arriving from the system bus and decides whether the bridge should forward it to one of two downstream ports. Software programs two address windows and a forwarding mode through a plain register write port. Each window is a lower and an upper bound. For every accepted transaction the block returns one result beat. The beat says whether the transaction is forwarded, which window (and so which downstream port) claimed it, and the 32-bit downstream address to use.

The upstream address is 40 bits wide. Only transactions in the extended I/O space are candidates: the top byte must be all ones and the next nibble must name the window's segment. A 12-bit field then has to fall in the window's half-open range. The low 16 address bits take no part in the compare. The downstream address drops the top byte, puts a nibble of ones in front, and clears the two byte-lane bits. In the broadcast mode it also forces the high part of the address to ones so that configuration writes reach every device.

Both streams use valid/ready. A transaction is accepted on a rising edge where `txn_valid` and `txn_ready` are both high. Its result appears on `fwd_*` after that same edge and stays there, unchanged, until a rising edge with `fwd_ready` high. `txn_ready` is high whenever the result register is empty or is being drained in the same cycle. So a stalled consumer stalls the producer after one result, and back-to-back traffic runs at one transaction per cycle.

Top module: `ioa_window_decoder`

## Requirements
- R1: After reset `fwd_valid` is low, `txn_ready` is high, the mode is off and every bound is zero. A transaction then produces a miss even once the pass-through mode is selected and no bound has been written.
- R2: A window matches address A when A[39:32] is 8'hFF, A[31:28] equals LOW[15:12], and A[27:16] is at least LOW[11:0] and strictly less than HIGH[11:0]. A[15:0] and HIGH[15:12] do not affect the match.
- R3: A window whose LOW[11:0] is greater than or equal to its HIGH[11:0] matches no address.
- R4: In mode 0 (off) and in the reserved mode 2, every transaction produces a miss, even when it matches a window.
- R5: In mode 1 (pass-through), a matching transaction hits whatever its type. Its result address is {4'hF, A[27:2], 2'b00}.
- R6: In mode 3 (broadcast), only matching transactions with `txn_wr_short` high hit. Their result address is the R5 address with bits [31:18] forced to ones. A matching transaction with `txn_wr_short` low produces a miss.
- R7: When both windows match, window 0 wins. `fwd_port` gives the index of the winning window (0 or 1).
- R8: A register write takes effect for a transaction accepted in the same cycle as the write, and for every later transaction.
- R9: The result of a transaction accepted at clock edge N is valid after edge N. A miss result carries `fwd_hit`=0, `fwd_port`=0 and `fwd_addr`=0.
- R10: While `fwd_valid` is high and `fwd_ready` is low, `txn_ready` is low and the result beat holds its value. When `fwd_ready` returns high, a waiting transaction is accepted in the same cycle that the old result drains.
- R11: Register select values are: 0 is the control register, with the mode in data[1:0]; 1 is LOW0; 2 is HIGH0; 3 is LOW1; 4 is HIGH1. Bounds take data[15:0]. Writes to select values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (R11) |
| cfg_wr_data | input | 16 | Register write data |
| txn_valid | input | 1 | Upstream transaction valid |
| txn_ready | output | 1 | Block can accept a transaction |
| txn_addr | input | 40 | Upstream transaction address |
| txn_wr_short | input | 1 | Transaction is a short write |
| fwd_valid | output | 1 | Result beat valid |
| fwd_ready | input | 1 | Consumer takes the result beat |
| fwd_hit | output | 1 | Transaction is forwarded |
| fwd_port | output | 1 | Index of the claiming window |
| fwd_addr | output | 32 | Downstream address |

## Verification
The hardest case to reach from the ports is a bound or mode write landing on the very edge that accepts a transaction. Only that case shows whether the new value reaches the compare at once or one cycle late. The bench raises the write strobe and the transaction valid in the same cycle. It picks values for which the old and new register contents give different results. A second hard case is a new transaction waiting while the result register is stalled. The bench holds `fwd_ready` low across two cycles with a second address on the input, then releases it. It checks that the first beat stayed put and that the second is taken on the release edge.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
package iowin_pkg;
  typedef enum logic [1:0] {
    FWD_OFF   = 2'd0,
    FWD_PASS  = 2'd1,
    FWD_RSVD  = 2'd2,
    FWD_BCAST = 2'd3
  } fwd_mode_t;
endpackage

// File: rtl/iowin_regfile.sv
`timescale 1ns/1ps
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int BOUND_W = 16,
  parameter int SEL_W   = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [BOUND_W-1:0]                wr_data,
  output fwd_mode_t                         eff_mode,
  output logic [NUM_WIN-1:0][BOUND_W-1:0]   eff_low,
  output logic [NUM_WIN-1:0][BOUND_W-1:0]   eff_high
);
  localparam logic [SEL_W-1:0] CTL_SEL = '0;

  fwd_mode_t mode_q;
  logic      ctl_hit;
  logic      unused_ctl_bits;

  assign ctl_hit         = wr_en && (wr_sel == CTL_SEL);
  assign unused_ctl_bits = ^wr_data[BOUND_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= FWD_OFF;
    else if (ctl_hit) mode_q <= fwd_mode_t'(wr_data[1:0]);
  end

  // same-cycle write bypass so the accepted transaction sees new contents
  assign eff_mode = ctl_hit ? fwd_mode_t'(wr_data[1:0]) : mode_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(2 * w + 1);
    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 * w + 2);
    logic [BOUND_W-1:0] low_q, high_q;
    logic lo_hit, hi_hit;

    assign lo_hit = wr_en && (wr_sel == LO_SEL);
    assign hi_hit = wr_en && (wr_sel == HI_SEL);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        low_q  <= '0;
        high_q <= '0;
      end else begin
        if (lo_hit) low_q  <= wr_data;
        if (hi_hit) high_q <= wr_data;
      end
    end

    assign eff_low[w]  = lo_hit ? wr_data : low_q;
    assign eff_high[w] = hi_hit ? wr_data : high_q;
  end
endmodule

// File: rtl/iowin_window_cmp.sv
`timescale 1ns/1ps
module iowin_window_cmp #(
  parameter int PREFIX_W = 8,
  parameter int SEG_W    = 4,
  parameter int RANGE_W  = 12,
  localparam int CMP_W   = PREFIX_W + SEG_W + RANGE_W,
  localparam int BOUND_W = SEG_W + RANGE_W
) (
  input  logic [CMP_W-1:0]   addr_hi,
  input  logic [BOUND_W-1:0] low_bound,
  input  logic [BOUND_W-1:0] high_bound,
  output logic               match
);
  logic               prefix_ok, seg_ok, above_low, below_high;
  logic [RANGE_W-1:0] range_fld;
  logic               unused_high_seg;

  assign prefix_ok       = &addr_hi[CMP_W-1 -: PREFIX_W];
  assign seg_ok          = addr_hi[BOUND_W-1 -: SEG_W] == low_bound[BOUND_W-1 -: SEG_W];
  assign range_fld       = addr_hi[RANGE_W-1:0];
  assign above_low       = range_fld >= low_bound[RANGE_W-1:0];
  assign below_high      = range_fld <  high_bound[RANGE_W-1:0];
  assign unused_high_seg = ^high_bound[BOUND_W-1 -: SEG_W];

  assign match = prefix_ok && seg_ok && above_low && below_high;
endmodule

// File: rtl/iowin_route.sv
`timescale 1ns/1ps
module iowin_route
  import iowin_pkg::*;
#(
  parameter int NUM_WIN   = 2,
  parameter int DN_AW     = 32,
  parameter int LEAD_W    = 4,
  parameter int PEEK_ONES = 14,
  localparam int MID_W    = DN_AW - LEAD_W - 2,
  localparam int PORT_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] match,
  input  fwd_mode_t          mode,
  input  logic               wr_short,
  input  logic [MID_W-1:0]   addr_mid,
  output logic               hit,
  output logic [PORT_W-1:0]  port,
  output logic [DN_AW-1:0]   dn_addr
);
  localparam logic [DN_AW-1:0] PEEK_MASK = {{PEEK_ONES{1'b1}}, {(DN_AW-PEEK_ONES){1'b0}}};

  logic              any_match, allow;
  logic [PORT_W-1:0] pick;
  logic [DN_AW-1:0]  base_addr;

  always_comb begin
    pick = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) pick = PORT_W'(w);
    end
  end

  assign any_match = |match;
  assign allow     = (mode == FWD_PASS) || ((mode == FWD_BCAST) && wr_short);
  assign base_addr = {{LEAD_W{1'b1}}, addr_mid, 2'b00};

  always_comb begin
    hit     = any_match && allow;
    port    = '0;
    dn_addr = '0;
    if (hit) begin
      port    = pick;
      dn_addr = (mode == FWD_BCAST) ? (base_addr | PEEK_MASK) : base_addr;
    end
  end
endmodule

// File: rtl/ioa_window_decoder.sv
`timescale 1ns/1ps
module ioa_window_decoder
  import iowin_pkg::*;
#(
  parameter int UP_AW     = 40,
  parameter int DN_AW     = 32,
  parameter int NUM_WIN   = 2,
  parameter int PREFIX_W  = 8,
  parameter int SEG_W     = 4,
  parameter int RANGE_W   = 12,
  parameter int PEEK_ONES = 14,
  localparam int BOUND_W  = SEG_W + RANGE_W,
  localparam int SEL_W    = $clog2(2 * NUM_WIN + 1),
  localparam int PORT_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [SEL_W-1:0]   cfg_wr_sel,
  input  logic [BOUND_W-1:0] cfg_wr_data,
  input  logic               txn_valid,
  output logic               txn_ready,
  input  logic [UP_AW-1:0]   txn_addr,
  input  logic               txn_wr_short,
  output logic               fwd_valid,
  input  logic               fwd_ready,
  output logic               fwd_hit,
  output logic [PORT_W-1:0]  fwd_port,
  output logic [DN_AW-1:0]   fwd_addr
);
  localparam int CMP_W   = PREFIX_W + SEG_W + RANGE_W;
  localparam int CMP_LSB = UP_AW - CMP_W;
  localparam int SEG_LSB = UP_AW - PREFIX_W - SEG_W;
  localparam int MID_W   = DN_AW - SEG_W - 2;
  localparam int MID_LSB = SEG_LSB - MID_W;

  fwd_mode_t                       eff_mode;
  logic [NUM_WIN-1:0][BOUND_W-1:0] eff_low, eff_high;
  logic [NUM_WIN-1:0]              win_match;
  logic                            nxt_hit, accept;
  logic [PORT_W-1:0]               nxt_port;
  logic [DN_AW-1:0]                nxt_addr;
  logic                            unused_addr_lo;

  assign unused_addr_lo = ^txn_addr[MID_LSB-1:0];

  iowin_regfile #(
    .NUM_WIN (NUM_WIN),
    .BOUND_W (BOUND_W),
    .SEL_W   (SEL_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_sel   (cfg_wr_sel),
    .wr_data  (cfg_wr_data),
    .eff_mode (eff_mode),
    .eff_low  (eff_low),
    .eff_high (eff_high)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    iowin_window_cmp #(
      .PREFIX_W (PREFIX_W),
      .SEG_W    (SEG_W),
      .RANGE_W  (RANGE_W)
    ) u_cmp (
      .addr_hi    (txn_addr[UP_AW-1:CMP_LSB]),
      .low_bound  (eff_low[w]),
      .high_bound (eff_high[w]),
      .match      (win_match[w])
    );
  end

  iowin_route #(
    .NUM_WIN   (NUM_WIN),
    .DN_AW     (DN_AW),
    .LEAD_W    (SEG_W),
    .PEEK_ONES (PEEK_ONES)
  ) u_route (
    .match    (win_match),
    .mode     (eff_mode),
    .wr_short (txn_wr_short),
    .addr_mid (txn_addr[SEG_LSB-1:MID_LSB]),
    .hit      (nxt_hit),
    .port     (nxt_port),
    .dn_addr  (nxt_addr)
  );

  assign txn_ready = !fwd_valid || fwd_ready;
  assign accept    = txn_valid && txn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_port  <= '0;
      fwd_addr  <= '0;
    end else if (txn_ready) begin
      fwd_valid <= txn_valid;
      if (accept) begin
        fwd_hit  <= nxt_hit;
        fwd_port <= nxt_port;
        fwd_addr <= nxt_addr;
      end
    end
  end
endmodule

// File: rtl/iowin_checker.sv
`timescale 1ns/1ps
module iowin_checker #(
  parameter int UP_AW  = 40,
  parameter int DN_AW  = 32,
  parameter int PORT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [UP_AW-1:0]  txn_addr,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic              fwd_hit,
  input logic [PORT_W-1:0] fwd_port,
  input logic [DN_AW-1:0]  fwd_addr
);
  // R10: a stalled beat keeps its contents
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_hit) && $stable(fwd_port) && $stable(fwd_addr));

  // R10: no acceptance while stalled
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |-> !txn_ready);

  // R9: accepted transaction yields a beat after that edge
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> fwd_valid);

  // R9: no beat appears without an accepted transaction
  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_valid && txn_ready) && (fwd_ready || !fwd_valid) |=> !fwd_valid);

  // R9: miss beats carry zeros
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_hit |-> fwd_addr == '0 && fwd_port == '0);

  // R2: addresses outside the all-ones prefix never hit
  assert_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready && !(&txn_addr[UP_AW-1 -: 8]) |=> !fwd_hit);

  // R5: hit addresses lead with ones and have cleared byte-lane bits
  assert_lead_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_hit |-> fwd_addr[DN_AW-1 -: 4] == 4'hF && fwd_addr[1:0] == 2'b00);
endmodule

bind ioa_window_decoder iowin_checker #(
  .UP_AW  (UP_AW),
  .DN_AW  (DN_AW),
  .PORT_W (PORT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_valid (txn_valid),
  .txn_ready (txn_ready),
  .txn_addr  (txn_addr),
  .fwd_valid (fwd_valid),
  .fwd_ready (fwd_ready),
  .fwd_hit   (fwd_hit),
  .fwd_port  (fwd_port),
  .fwd_addr  (fwd_addr)
);

// File: tb/ioa_window_decoder_tb.sv
`timescale 1ns/1ps
module ioa_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_sel = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic [39:0] txn_addr = '0;
  logic        txn_wr_short = 1'b0;
  logic        fwd_valid;
  logic        fwd_ready = 1'b1;
  logic        fwd_hit;
  logic [0:0]  fwd_port;
  logic [31:0] fwd_addr;

  int total = 0;
  int bad = 0;

  logic [15:0] m_low [2];
  logic [15:0] m_high[2];
  logic [1:0]  m_mode;

  always #2.5 clk = ~clk;

  ioa_window_decoder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .cfg_wr_data  (cfg_wr_data),
    .txn_valid    (txn_valid),
    .txn_ready    (txn_ready),
    .txn_addr     (txn_addr),
    .txn_wr_short (txn_wr_short),
    .fwd_valid    (fwd_valid),
    .fwd_ready    (fwd_ready),
    .fwd_hit      (fwd_hit),
    .fwd_port     (fwd_port),
    .fwd_addr     (fwd_addr)
  );

  function automatic logic [39:0] mk(input logic [3:0] seg, input logic [11:0] rng, input logic [15:0] lo);
    return {8'hFF, seg, rng, lo};
  endfunction

  // expected {hit, port, addr} from the requirements
  function automatic logic [33:0] ref_out(input logic [39:0] a, input logic ws);
    logic [1:0]  m;
    logic        allow;
    logic [31:0] da;
    for (int w = 0; w < 2; w++) begin
      m[w] = (a[39:32] == 8'hFF) && (a[31:28] == m_low[w][15:12]) &&
             (a[27:16] >= m_low[w][11:0]) && (a[27:16] < m_high[w][11:0]);
    end
    allow = (m_mode == 2'd1) || (m_mode == 2'd3 && ws);
    if (!(allow && (m != 2'b00))) return '0;
    da = {4'hF, a[27:2], 2'b00};
    if (m_mode == 2'd3) da = da | 32'hFFFC_0000;
    return {1'b1, (m[0] ? 1'b0 : 1'b1), da};
  endfunction

  task automatic model_write(input logic [2:0] sel, input logic [15:0] d);
    case (sel)
      3'd0: m_mode = d[1:0];
      3'd1: m_low[0] = d;
      3'd2: m_high[0] = d;
      3'd3: m_low[1] = d;
      3'd4: m_high[1] = d;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(sel, d);
  endtask

  task automatic send(input string req, input logic [39:0] a, input logic ws);
    logic [33:0] exp;
    @(negedge clk);
    fwd_ready = 1'b1;
    txn_valid = 1'b1; txn_addr = a; txn_wr_short = ws;
    exp = ref_out(a, ws);
    @(negedge clk);
    txn_valid = 1'b0;
    check({req, " valid"}, {33'd0, fwd_valid}, 34'd1);
    check(req, {fwd_hit, fwd_port, fwd_addr}, exp);
  endtask

  task automatic t_reset;
    check("R1 fwd_valid after reset", {33'd0, fwd_valid}, 34'd0);
    check("R1 txn_ready after reset", {33'd0, txn_ready}, 34'd1);
    send("R1 off mode default", mk(4'h0, 12'h000, 16'h0), 1'b1);
    reg_write(3'd0, 16'h0001);
    send("R1 zero bounds miss", mk(4'h0, 12'h000, 16'h0), 1'b0);
  endtask

  task automatic t_range;
    reg_write(3'd1, 16'h3100); reg_write(3'd2, 16'h3200);
    reg_write(3'd3, 16'h5400); reg_write(3'd4, 16'h5800);
    send("R2 low edge hit", mk(4'h3, 12'h100, 16'h0000), 1'b0);
    send("R2 top inside hit", mk(4'h3, 12'h1FF, 16'hFFFF), 1'b1);
    send("R2 high exclusive", mk(4'h3, 12'h200, 16'h0), 1'b0);
    send("R2 below low", mk(4'h3, 12'h0FF, 16'h0), 1'b0);
    send("R2 segment mismatch", mk(4'h4, 12'h150, 16'h0), 1'b0);
    send("R2 prefix not ones", {8'hFE, 4'h3, 12'h150, 16'h0}, 1'b0);
    send("R5 pass address window1", mk(4'h5, 12'h500, 16'h1234), 1'b0);
    send("R5 pass address bits", mk(4'h3, 12'h1A5, 16'hA5A7), 1'b0);
  endtask

  task automatic t_overlap;
    reg_write(3'd3, 16'h3180); reg_write(3'd4, 16'h3300);
    send("R7 both match window0", mk(4'h3, 12'h190, 16'h0), 1'b0);
    send("R7 only window1", mk(4'h3, 12'h250, 16'h0), 1'b0);
  endtask

  task automatic t_disable;
    reg_write(3'd1, 16'h3200); reg_write(3'd2, 16'h3200);
    reg_write(3'd3, 16'h5400); reg_write(3'd4, 16'h5800);
    send("R3 equal bounds", mk(4'h3, 12'h200, 16'h0), 1'b0);
    reg_write(3'd1, 16'h3300); reg_write(3'd2, 16'h3100);
    send("R3 inverted bounds", mk(4'h3, 12'h200, 16'h0), 1'b0);
    send("R3 inverted bounds edge", mk(4'h3, 12'h300, 16'h0), 1'b0);
  endtask

  task automatic t_modes;
    reg_write(3'd1, 16'h3100); reg_write(3'd2, 16'h3200);
    reg_write(3'd0, 16'h0003);
    send("R6 bcast write short", mk(4'h3, 12'h123, 16'h4567), 1'b1);
    send("R6 bcast other type", mk(4'h3, 12'h123, 16'h4567), 1'b0);
    send("R6 bcast window1", mk(4'h5, 12'h7FF, 16'h0), 1'b1);
    reg_write(3'd0, 16'h0000);
    send("R4 off mode", mk(4'h3, 12'h123, 16'h0), 1'b1);
    reg_write(3'd0, 16'h0002);
    send("R4 reserved mode", mk(4'h3, 12'h123, 16'h0), 1'b1);
    reg_write(3'd0, 16'hFFF1);
    send("R11 mode from low bits", mk(4'h3, 12'h123, 16'h0), 1'b0);
  endtask

  task automatic t_bad_sel;
    reg_write(3'd5, 16'h0000);
    reg_write(3'd6, 16'h0000);
    reg_write(3'd7, 16'h0000);
    send("R11 unused selects ignored", mk(4'h3, 12'h150, 16'h0), 1'b0);
  endtask

  task automatic t_bypass;
    logic [33:0] exp;
    // same-cycle write moves LOW0 above the address: expect miss
    @(negedge clk);
    fwd_ready = 1'b1;
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd1; cfg_wr_data = 16'h3180;
    txn_valid = 1'b1; txn_addr = mk(4'h3, 12'h120, 16'h0); txn_wr_short = 1'b0;
    model_write(3'd1, 16'h3180);
    exp = ref_out(txn_addr, 1'b0);
    @(negedge clk);
    cfg_wr_en = 1'b0; txn_valid = 1'b0;
    check("R8 bypass bound", {fwd_hit, fwd_port, fwd_addr}, exp);
    check("R8 bypass bound expect miss", {33'd0, fwd_hit}, 34'd0);
    // same-cycle mode write to off
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd0; cfg_wr_data = 16'h0000;
    txn_valid = 1'b1; txn_addr = mk(4'h3, 12'h190, 16'h0);
    model_write(3'd0, 16'h0000);
    exp = ref_out(txn_addr, 1'b0);
    @(negedge clk);
    cfg_wr_en = 1'b0; txn_valid = 1'b0;
    check("R8 bypass mode", {fwd_hit, fwd_port, fwd_addr}, exp);
    reg_write(3'd0, 16'h0001);
    send("R8 later transaction", mk(4'h3, 12'h190, 16'h0), 1'b0);
  endtask

  task automatic t_backpressure;
    logic [33:0] exp_a, exp_b;
    logic [39:0] a_addr, b_addr;
    a_addr = mk(4'h3, 12'h1C0, 16'h0);
    b_addr = mk(4'h5, 12'h600, 16'h0);
    @(negedge clk);
    txn_valid = 1'b0; fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    txn_valid = 1'b1; txn_addr = a_addr;
    exp_a = ref_out(a_addr, 1'b0);
    exp_b = ref_out(b_addr, 1'b0);
    @(negedge clk);
    txn_addr = b_addr;
    check("R10 first beat", {fwd_hit, fwd_port, fwd_addr}, exp_a);
    check("R10 ready low while stalled", {33'd0, txn_ready}, 34'd0);
    @(negedge clk);
    check("R10 beat held", {fwd_hit, fwd_port, fwd_addr}, exp_a);
    check("R10 still valid", {33'd0, fwd_valid}, 34'd1);
    fwd_ready = 1'b1;
    @(negedge clk);
    txn_valid = 1'b0;
    check("R10 second beat after release", {fwd_hit, fwd_port, fwd_addr}, exp_b);
    @(negedge clk);
    check("R9 drained", {33'd0, fwd_valid}, 34'd0);
  endtask

  initial begin
    m_low[0] = '0; m_low[1] = '0; m_high[0] = '0; m_high[1] = '0; m_mode = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_range();
    t_overlap();
    t_disable();
    t_modes();
    t_bad_sel();
    t_bypass();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule